// File: doc/BRIEF.md
# Alarm Comparator and Shared Interrupt Pin Driver

This block is the alarm section of a real-time clock. It holds no time of its own. Each second, on the tick from the time counters, it compares the current BCD seconds, minutes, hours, day-of-month and month with a set of stored alarm values. A five-bit repeat code chooses how many of those fields take part in the comparison. When the chosen fields agree, a sticky alarm flag is set. The bus side clears the flag by reading the flag register.

The block also drives one open-drain pin that serves three purposes, chosen by two control bits:
- a programmable square wave taken from the prescaler taps,
- the alarm interrupt,
- a static level set by a software output bit.

The pin is modelled as an active-high pull-down enable. The bus interface supplies the register pointer and a read strobe for the flag register. While the pointer rests on the flag register, a new alarm is held back. It is delivered once the pointer moves away.

Top module: `alarm_pin_unit`

## Requirements
- R1: Repeat code 5'b11111 sets the flag on every second tick, whatever the field values.
- R2: Repeat code 5'b11110 requires only the seconds field (bits 6:0) to match. The other fields are ignored.
- R3: Repeat code 5'b11100 requires seconds and minutes (bits 6:0) to match.
- R4: Repeat code 5'b11000 additionally requires hours (bits 5:0) to match. The bits above 5 of the current hour byte are ignored.
- R5: Repeat code 5'b10000 additionally requires the day-of-month field (bits 5:0) to match.
- R6: Repeat code 5'b00000 additionally requires the month field (bits 4:0) to match.
- R7: Any other repeat code behaves as 5'b11111 and fires on every tick.
- R8: The flag sets at the clock edge that samples a tick together with a match. Without a further event it then stays set, including on later ticks that do not match.
- R9: A flag-register read strobe clears the flag at the next edge.
- R10: A match on a tick while the register pointer equals 5'h0F does not set the flag. The flag sets at the first edge at which the pointer differs from 5'h0F.
- R11: With square-wave enable at 1, a rate code of 0 releases the pin. A rate code n from 1 to 15 pulls the pin low exactly while prescaler tap n-1 is low. Tap 0 is the 32,768 Hz square wave, and each following tap is half the frequency of the one before.
- R12: With square-wave enable at 0 and flag enable at 1, the pin is pulled low exactly while the alarm flag is set.
- R13: With both enables at 0, the pin is pulled low exactly when the output bit is 0.
- R14: During reset the flag is clear and no deferred alarm is retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| secTick | input | 1 | One-cycle pulse at each whole second (hundredths at 00) |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD in bits 5:0 |
| curDate | input | 8 | Current day of month, BCD |
| curMonth | input | 8 | Current month, BCD |
| almSec | input | 8 | Alarm seconds, BCD |
| almMin | input | 8 | Alarm minutes, BCD |
| almHour | input | 8 | Alarm hours, BCD |
| almDate | input | 8 | Alarm day of month, BCD |
| almMonth | input | 8 | Alarm month, BCD |
| rptCode | input | 5 | Repeat code, bit 4 most significant |
| flagEn | input | 1 | Routes the alarm flag to the pin |
| sqwEn | input | 1 | Routes the square wave to the pin, overriding the flag |
| outBit | input | 1 | Static pin level when both enables are 0 |
| rateSel | input | 4 | Square-wave rate code |
| prescTaps | input | 15 | Prescaler taps, tap 0 at 32,768 Hz |
| regPtr | input | 5 | Current register pointer of the bus interface |
| flagRead | input | 1 | Pulse when the flag register is read |
| alarmFlag | output | 1 | Sticky alarm flag |
| pinPullDown | output | 1 | Pull-down enable of the open-drain pin |

## Verification
The hardest case to reach is the deferred alarm. A matching tick has to arrive exactly while the pointer sits on the flag register, and the flag must then stay clear across that tick. The flag must set only when the pointer later moves, which happens with no tick present. The bench parks the pointer at 5'h0F with the pin routed to the alarm and fires a tick under the every-second code. It checks both the flag and the pin on that cycle and again after it moves the pointer. Each repeat code is exercised twice: once with a mismatch in the lowest field it ignores, and once with a mismatch in the highest field it requires.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  localparam int NUM_FIELDS = 5;  // 0 sec, 1 min, 2 hour, 3 date, 4 month

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
  } flag_strb_t;

  // Significant bits of each BCD field.
  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      0, 1:    return 8'h7F;
      2, 3:    return 8'h3F;
      default: return 8'h1F;
    endcase
  endfunction

  // Which fields must agree for a given repeat code; unknown codes fire every second.
  function automatic logic [NUM_FIELDS-1:0] required_fields(input logic [4:0] code);
    case (code)
      5'b11110: return 5'b00001;
      5'b11100: return 5'b00011;
      5'b11000: return 5'b00111;
      5'b10000: return 5'b01111;
      5'b00000: return 5'b11111;
      default:  return 5'b00000;
    endcase
  endfunction

endpackage

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl
  import alarm_pkg::*;
#(
  parameter int PTR_W     = 5,
  parameter int FLAG_ADDR = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             secTick,
  input  logic             matchHit,
  input  logic [PTR_W-1:0] regPtr,
  input  logic             flagRead,
  output flag_strb_t       strb
);

  logic onFlag;
  logic tickHit;
  logic pendQ;

  assign onFlag  = (regPtr == PTR_W'(FLAG_ADDR));
  assign tickHit = secTick && matchHit;

  always_comb begin
    strb.setFlag = (tickHit || pendQ) && !onFlag;
    strb.clrFlag = flagRead;
  end

  // Deferred alarm held while the pointer sits on the flag register (R10).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pendQ <= 1'b0;
    else if (tickHit && onFlag) pendQ <= 1'b1;
    else if (!onFlag)           pendQ <= 1'b0;
  end

  p_pending_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pendQ && onFlag && !flagRead) |=> pendQ);

endmodule

// File: rtl/alarm_match_dp.sv
module alarm_match_dp
  import alarm_pkg::*;
#(
  parameter int FIELD_W   = 8,
  parameter int RATE_W    = 4,
  parameter int PTR_W     = 5,
  parameter int FLAG_ADDR = 15,
  localparam int TAP_W    = (1 << RATE_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] curSec,
  input  logic [FIELD_W-1:0] curMin,
  input  logic [FIELD_W-1:0] curHour,
  input  logic [FIELD_W-1:0] curDate,
  input  logic [FIELD_W-1:0] curMonth,
  input  logic [FIELD_W-1:0] almSec,
  input  logic [FIELD_W-1:0] almMin,
  input  logic [FIELD_W-1:0] almHour,
  input  logic [FIELD_W-1:0] almDate,
  input  logic [FIELD_W-1:0] almMonth,
  input  logic [4:0]         rptCode,
  input  flag_strb_t         strb,
  input  logic               sqwEn,
  input  logic               flagEn,
  input  logic               outBit,
  input  logic [RATE_W-1:0]  rateSel,
  input  logic [TAP_W-1:0]   prescTaps,
  input  logic [PTR_W-1:0]   regPtr,
  output logic               matchHit,
  output logic               alarmFlag,
  output logic               pinPullDown
);

  logic [FIELD_W-1:0]    curArr [NUM_FIELDS];
  logic [FIELD_W-1:0]    almArr [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fieldEq;
  logic [NUM_FIELDS-1:0] reqMask;
  logic                  tapLevel;

  assign curArr = '{curSec, curMin, curHour, curDate, curMonth};
  assign almArr = '{almSec, almMin, almHour, almDate, almMonth};

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [FIELD_W-1:0] MASK = FIELD_W'(field_mask(i));
    assign fieldEq[i] = ((curArr[i] ^ almArr[i]) & MASK) == '0;
  end

  assign reqMask  = required_fields(rptCode);
  assign matchHit = &(fieldEq | ~reqMask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            alarmFlag <= 1'b0;
    else if (strb.clrFlag) alarmFlag <= 1'b0;
    else if (strb.setFlag) alarmFlag <= 1'b1;
  end

  assign tapLevel = (rateSel == '0) ? 1'b1 : prescTaps[rateSel - RATE_W'(1)];

  always_comb begin
    if (sqwEn)       pinPullDown = !tapLevel;
    else if (flagEn) pinPullDown = alarmFlag;
    else             pinPullDown = !outBit;
  end

  p_no_set_on_flag_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarmFlag) |-> ($past(regPtr) != PTR_W'(FLAG_ADDR)));

  p_static_pin_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!sqwEn && !flagEn) |-> (pinPullDown == !outBit));

  p_rate_zero_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sqwEn && rateSel == '0) |-> !pinPullDown);

endmodule

// File: rtl/alarm_pin_unit.sv
module alarm_pin_unit
  import alarm_pkg::*;
#(
  parameter int FIELD_W   = 8,
  parameter int RATE_W    = 4,
  parameter int PTR_W     = 5,
  parameter int FLAG_ADDR = 15,
  localparam int TAP_W    = (1 << RATE_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               secTick,
  input  logic [FIELD_W-1:0] curSec,
  input  logic [FIELD_W-1:0] curMin,
  input  logic [FIELD_W-1:0] curHour,
  input  logic [FIELD_W-1:0] curDate,
  input  logic [FIELD_W-1:0] curMonth,
  input  logic [FIELD_W-1:0] almSec,
  input  logic [FIELD_W-1:0] almMin,
  input  logic [FIELD_W-1:0] almHour,
  input  logic [FIELD_W-1:0] almDate,
  input  logic [FIELD_W-1:0] almMonth,
  input  logic [4:0]         rptCode,
  input  logic               flagEn,
  input  logic               sqwEn,
  input  logic               outBit,
  input  logic [RATE_W-1:0]  rateSel,
  input  logic [TAP_W-1:0]   prescTaps,
  input  logic [PTR_W-1:0]   regPtr,
  input  logic               flagRead,
  output logic               alarmFlag,
  output logic               pinPullDown
);

  flag_strb_t strb;
  logic       matchHit;

  alarm_flag_ctrl #(.PTR_W(PTR_W), .FLAG_ADDR(FLAG_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .secTick(secTick), .matchHit(matchHit),
    .regPtr(regPtr), .flagRead(flagRead), .strb(strb)
  );

  alarm_match_dp #(.FIELD_W(FIELD_W), .RATE_W(RATE_W), .PTR_W(PTR_W),
                   .FLAG_ADDR(FLAG_ADDR)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDate(curDate),
    .curMonth(curMonth), .almSec(almSec), .almMin(almMin), .almHour(almHour),
    .almDate(almDate), .almMonth(almMonth), .rptCode(rptCode), .strb(strb),
    .sqwEn(sqwEn), .flagEn(flagEn), .outBit(outBit), .rateSel(rateSel),
    .prescTaps(prescTaps), .regPtr(regPtr), .matchHit(matchHit),
    .alarmFlag(alarmFlag), .pinPullDown(pinPullDown)
  );

  p_clear_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flagRead |=> !alarmFlag);

  p_set_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarmFlag) |-> ($past(secTick) || $past(regPtr) != PTR_W'(FLAG_ADDR)));

endmodule

// File: tb/sim_alarm_pin_unit.sv
`timescale 1ns/1ps
module sim_alarm_pin_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        secTick = 1'b0;
  logic [7:0]  cur [5];
  logic [7:0]  alm [5];
  logic [4:0]  rptCode = 5'b11111;
  logic        flagEn = 1'b0, sqwEn = 1'b0, outBit = 1'b1;
  logic [3:0]  rateSel = 4'd0;
  logic [14:0] prescTaps = '0;
  logic [4:0]  regPtr = 5'd0;
  logic        flagRead = 1'b0;
  logic        alarmFlag, pinPullDown;
  int          nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  alarm_pin_unit u0 (
    .clk(clk), .rst_n(rst_n), .secTick(secTick),
    .curSec(cur[0]), .curMin(cur[1]), .curHour(cur[2]), .curDate(cur[3]), .curMonth(cur[4]),
    .almSec(alm[0]), .almMin(alm[1]), .almHour(alm[2]), .almDate(alm[3]), .almMonth(alm[4]),
    .rptCode(rptCode), .flagEn(flagEn), .sqwEn(sqwEn), .outBit(outBit), .rateSel(rateSel),
    .prescTaps(prescTaps), .regPtr(regPtr), .flagRead(flagRead),
    .alarmFlag(alarmFlag), .pinPullDown(pinPullDown)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic load_time();
    cur = '{8'h30, 8'h45, 8'h12, 8'h15, 8'h06};
    alm = cur;
  endtask

  // One tick pulse; sample the flag after the edge that takes it.
  task automatic tick_expect(input string tag, input logic exp);
    @(negedge clk) secTick = 1'b1;
    @(negedge clk) secTick = 1'b0;
    chk(tag, alarmFlag, exp);
  endtask

  task automatic clear_flag();
    @(negedge clk) begin regPtr = 5'h0F; flagRead = 1'b1; end
    @(negedge clk) begin flagRead = 1'b0; regPtr = 5'h00; end
  endtask

  // nReq fields required: miss in lowest ignored field still fires, miss in highest required does not.
  task automatic t_mode(input logic [4:0] code, input int nReq, input string tag);
    rptCode = code;
    load_time();
    tick_expect({tag, " all equal"}, 1'b1);
    clear_flag();
    if (nReq < 5) begin
      alm[nReq] = alm[nReq] ^ 8'h01;
      tick_expect({tag, " ignored field differs"}, 1'b1);
      clear_flag();
      load_time();
    end
    if (nReq > 0) begin
      alm[nReq-1] = alm[nReq-1] ^ 8'h01;
      tick_expect({tag, " required field differs"}, 1'b0);
      clear_flag();
      load_time();
    end
  endtask

  task automatic t_reset();
    chk("R14 flag clear in reset", alarmFlag, 1'b0);
    chk("R13 pin released in reset with out=1", pinPullDown, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk) chk("R14 flag clear after reset", alarmFlag, 1'b0);
  endtask

  task automatic t_sticky_and_clear();
    rptCode = 5'b11110; load_time();
    tick_expect("R8 flag sets on match", 1'b1);
    alm[0] = 8'h31;
    tick_expect("R8 flag stays set on non-match", 1'b1);
    @(negedge clk) begin regPtr = 5'h0F; flagRead = 1'b1; end
    @(negedge clk) begin flagRead = 1'b0; end
    chk("R9 read clears flag", alarmFlag, 1'b0);
    regPtr = 5'h00; load_time();
  endtask

  task automatic t_hour_upper_bits();
    rptCode = 5'b11000; load_time();
    cur[2] = 8'hC2 & 8'hFF; cur[2][5:0] = 6'h12;
    tick_expect("R4 upper hour bits ignored", 1'b1);
    clear_flag(); load_time();
  endtask

  task automatic t_deferred();
    rptCode = 5'b11111; flagEn = 1'b1; sqwEn = 1'b0; load_time();
    @(negedge clk) begin regPtr = 5'h0F; secTick = 1'b1; end
    @(negedge clk) secTick = 1'b0;
    chk("R10 no flag while pointer on flag reg", alarmFlag, 1'b0);
    chk("R10 pin idle while pointer on flag reg", pinPullDown, 1'b0);
    @(negedge clk) chk("R10 still held", alarmFlag, 1'b0);
    regPtr = 5'h03;
    @(negedge clk);
    chk("R10 flag after pointer moves", alarmFlag, 1'b1);
    chk("R12 pin follows flag", pinPullDown, 1'b1);
    clear_flag();
    chk("R12 pin released after clear", pinPullDown, 1'b0);
  endtask

  task automatic t_sqw();
    sqwEn = 1'b1; flagEn = 1'b1;
    foreach (alm[i]) alm[i] = alm[i];
    for (int p = 0; p < 2; p++) begin
      prescTaps = (p == 0) ? 15'h5A5A : 15'h2C71;
      for (int n = 1; n < 16; n++) begin
        rateSel = 4'(n);
        @(negedge clk) chk($sformatf("R11 rate %0d pattern %0d", n, p), pinPullDown, !prescTaps[n-1]);
      end
    end
    prescTaps = '0; rateSel = 4'd0;
    @(negedge clk) chk("R11 rate 0 releases", pinPullDown, 1'b0);
    sqwEn = 1'b0; flagEn = 1'b0;
  endtask

  task automatic t_static();
    outBit = 1'b0;
    @(negedge clk) chk("R13 out=0 pulls low", pinPullDown, 1'b1);
    outBit = 1'b1;
    @(negedge clk) chk("R13 out=1 releases", pinPullDown, 1'b0);
  endtask

  initial begin
    load_time();
    repeat (3) @(negedge clk);
    t_reset();
    t_mode(5'b11111, 0, "R1");
    t_mode(5'b11110, 1, "R2");
    t_mode(5'b11100, 2, "R3");
    t_mode(5'b11000, 3, "R4");
    t_mode(5'b10000, 4, "R5");
    t_mode(5'b00000, 5, "R6");
    t_mode(5'b01010, 0, "R7 code 01010");
    t_mode(5'b11101, 0, "R7 code 11101");
    t_hour_upper_bits();
    t_sticky_and_clear();
    t_deferred();
    t_sqw();
    t_static();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule